// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer that sits between two unrelated clock domains. A producer pushes 18-bit words on the write clock and a consumer pops them on the read clock. The depth is a parameter and must be a power of two from 256 to 4096 words. All enables, the reset and every status output are active-low. Five status outputs describe the fill state. Full and half-full are computed on the write side and are registered-path signals of the write clock. Empty is computed on the read side. Almost-full and almost-empty use thresholds that software can change.

The two thresholds are held in a pair of 12-bit offset registers that share the normal data ports. While the load strobe is low, a write-enabled write-clock edge stores the low 12 input bits into one offset register and does not push a word. While the load strobe is low, a read-enabled read-clock edge shows one offset register on the low 12 output bits and does not pop a word. Each side has its own select pointer. The first access goes to the almost-empty offset, the next to the almost-full offset, and the pointer then alternates. After reset both offsets hold a default that depends on the depth.

Top module: `dc_prog_fifo`

## Requirements
- R1: While rstN is low and directly after it rises, fullN=1, almostFullN=1, halfFullN=1, emptyN=0, almostEmptyN=0 and dOut=0. Both pointers point at the first location.
- R2: A word is stored on a rising wrClk edge only when wrEnN=0, loadN=1 and fullN=1. A write attempted while fullN=0 changes neither the contents nor the level.
- R3: dOut takes a new word on a rising rdClk edge only when rdEnN=0, loadN=1 and emptyN=1. Otherwise dOut keeps its previous value, which includes a read attempted while emptyN=0.
- R4: Words leave in exactly the order in which they were accepted, including while both sides run at the same time.
- R5: fullN is 0 exactly when the write side sees DEPTH words stored.
- R6: emptyN is 0 exactly when the read side sees no word stored.
- R7: almostEmptyN is 0 when the stored count is less than or equal to the almost-empty offset.
- R8: almostFullN is 0 when the free space (DEPTH minus the count) is less than or equal to the almost-full offset.
- R9: halfFullN is 0 when the count is greater than DEPTH/2.
- R10: After reset both offsets are 31 for DEPTH 256, 63 for DEPTH 512, and 127 for DEPTH 1024 and above.
- R11: With loadN=0 and wrEnN=0, a rising wrClk edge writes dIn[11:0] to an offset register and pushes no data word. Successive loads go to the almost-empty offset, then the almost-full offset, then alternate, starting from the almost-empty offset after reset.
- R12: With loadN=0 and rdEnN=0, a rising rdClk edge puts the selected offset, zero-extended, on dOut and pops no data word. The selection starts at the almost-empty offset after reset and alternates independently of the write side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active-low, common to both sides |
| wrEnN | input | 1 | Write enable, active-low |
| rdEnN | input | 1 | Read enable, active-low |
| loadN | input | 1 | Offset-register access strobe, active-low |
| dIn | input | 18 | Write data, or offset value (low 12 bits) under loadN |
| dOut | output | 18 | Read data register, or offset readback under loadN |
| fullN | output | 1 | Low when full (write clock) |
| emptyN | output | 1 | Low when empty (read clock) |
| almostFullN | output | 1 | Low when free space is at or below the almost-full offset |
| almostEmptyN | output | 1 | Low when the count is at or below the almost-empty offset |
| halfFullN | output | 1 | Low when more than half full |

## Verification
The hardest state to reach from the ports is the one where a flag edge, an attempted write at full, or an attempted read at empty has to be judged while the other side's pointer is still in transit through the synchronizers. The bench reaches each threshold one word at a time and lets both synchronizers settle before it compares every flag against a count-based model. It then pushes an extra word into a full buffer and pops from an empty one. A final phase runs writer and reader at the same time with random gaps on unrelated clocks, so the buffer repeatedly fills and drains while ordering is checked on every accepted read.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
  // Strobes from the control block to the datapath.
  typedef struct packed {
    logic memWr;     // push one data word (write clock)
    logic ofsWr;     // load one offset register (write clock)
    logic ofsWrSel;  // 0: almost-empty offset, 1: almost-full offset
    logic memRd;     // pop one data word into dOut (read clock)
    logic ofsRd;     // put one offset register on dOut (read clock)
    logic ofsRdSel;  // 0: almost-empty offset, 1: almost-full offset
  } fifoStb_t;
endpackage

// File: rtl/fifo_sync.sv
`timescale 1ns/1ps
module fifo_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fifo_ctrl.sv
`timescale 1ns/1ps
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int OFS_W = 12,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             wrEnN,
  input  logic             rdEnN,
  input  logic             loadN,
  input  logic [OFS_W-1:0] aeOfs,
  input  logic [OFS_W-1:0] afOfs,
  output fifoStb_t         stb,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output logic             fullN,
  output logic             emptyN,
  output logic             almostFullN,
  output logic             almostEmptyN,
  output logic             halfFullN
);
  localparam int PW = AW + 1;
  localparam int CW = (PW > OFS_W) ? PW : OFS_W;
  localparam logic [PW-1:0] CAP  = PW'(DEPTH);
  localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write side ----------------
  logic [PW-1:0] wBin, wBinNxt, wGray, rGrayW, rBinW, wLevel, wFree;
  logic          wrAcc, ofsWrHit, wSel;

  assign wrAcc    = !wrEnN && loadN && fullN;
  assign ofsWrHit = !wrEnN && !loadN;
  assign wBinNxt  = wBin + 1'b1;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin  <= '0;
      wGray <= '0;
      wSel  <= 1'b0;
    end else begin
      if (wrAcc) begin
        wBin  <= wBinNxt;
        wGray <= wBinNxt ^ (wBinNxt >> 1);
      end
      if (ofsWrHit) wSel <= ~wSel;
    end
  end

  fifo_sync #(.W(PW)) uSyncR2W (
    .clk(wrClk), .rstN(rstN), .d(rGray), .q(rGrayW)
  );

  assign rBinW       = g2b(rGrayW);
  assign wLevel      = wBin - rBinW;
  assign wFree       = CAP - wLevel;
  assign fullN       = (wLevel != CAP);
  assign almostFullN = (CW'(wFree) > CW'(afOfs));
  assign halfFullN   = !(wLevel > HALF);
  assign wrAddr      = wBin[AW-1:0];

  // ---------------- read side ----------------
  logic [PW-1:0] rBin, rBinNxt, rGray, wGrayR, wBinR, rLevel;
  logic          rdAcc, ofsRdHit, rSel;

  assign rdAcc    = !rdEnN && loadN && emptyN;
  assign ofsRdHit = !rdEnN && !loadN;
  assign rBinNxt  = rBin + 1'b1;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rBin  <= '0;
      rGray <= '0;
      rSel  <= 1'b0;
    end else begin
      if (rdAcc) begin
        rBin  <= rBinNxt;
        rGray <= rBinNxt ^ (rBinNxt >> 1);
      end
      if (ofsRdHit) rSel <= ~rSel;
    end
  end

  fifo_sync #(.W(PW)) uSyncW2R (
    .clk(rdClk), .rstN(rstN), .d(wGray), .q(wGrayR)
  );

  assign wBinR        = g2b(wGrayR);
  assign rLevel       = wBinR - rBin;
  assign emptyN       = (rLevel != '0);
  assign almostEmptyN = (CW'(rLevel) > CW'(aeOfs));
  assign rdAddr       = rBin[AW-1:0];

  // ---------------- strobes ----------------
  always_comb begin
    stb          = '0;
    stb.memWr    = wrAcc;
    stb.ofsWr    = ofsWrHit;
    stb.ofsWrSel = wSel;
    stb.memRd    = rdAcc;
    stb.ofsRd    = ofsRdHit;
    stb.ofsRdSel = rSel;
  end

  // ---------------- assertions ----------------
  // R2
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (!fullN && !wrEnN && loadN) |=> $stable(wBin));
  // R3
  no_underflow_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (!emptyN && !rdEnN && loadN) |=> $stable(rBin));
  // R5
  wr_gray_step_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wGray ^ $past(wGray)) <= 1);
  // R6
  rd_gray_step_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rGray ^ $past(rGray)) <= 1);
  // R5
  wr_level_bound_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    wLevel <= CAP);
  // R6
  rd_level_bound_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    rLevel <= CAP);
  // R11
  load_no_push_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (!loadN && !wrEnN) |=> $stable(wBin));
  // R12
  load_no_pop_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (!loadN && !rdEnN) |=> $stable(rBin));
endmodule

// File: rtl/fifo_dp.sv
`timescale 1ns/1ps
module fifo_dp
  import fifo_pkg::*;
#(
  parameter int DW      = 18,
  parameter int DEPTH   = 256,
  parameter int OFS_W   = 12,
  parameter int DEF_OFS = 31,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  fifoStb_t         stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [DW-1:0]    dIn,
  output logic [DW-1:0]    dOut,
  output logic [OFS_W-1:0] aeOfs,
  output logic [OFS_W-1:0] afOfs
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.memWr) mem[wrAddr] <= dIn;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOfs <= OFS_W'(DEF_OFS);
      afOfs <= OFS_W'(DEF_OFS);
    end else if (stb.ofsWr) begin
      if (stb.ofsWrSel) afOfs <= dIn[OFS_W-1:0];
      else              aeOfs <= dIn[OFS_W-1:0];
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      dOut <= '0;
    end else if (stb.memRd) begin
      dOut <= mem[rdAddr];
    end else if (stb.ofsRd) begin
      dOut <= DW'(stb.ofsRdSel ? afOfs : aeOfs);
    end
  end

  // R11
  push_load_excl_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    !(stb.memWr && stb.ofsWr));
  // R3
  out_hold_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (!stb.memRd && !stb.ofsRd) |=> $stable(dOut));
endmodule

// File: rtl/dc_prog_fifo.sv
`timescale 1ns/1ps
module dc_prog_fifo
  import fifo_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  parameter int OFS_W = 12
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEnN,
  input  logic          rdEnN,
  input  logic          loadN,
  input  logic [DW-1:0] dIn,
  output logic [DW-1:0] dOut,
  output logic          fullN,
  output logic          emptyN,
  output logic          almostFullN,
  output logic          almostEmptyN,
  output logic          halfFullN
);
  localparam int AW      = $clog2(DEPTH);
  // R10: depth-dependent reset offset
  localparam int DEF_OFS = (DEPTH <= 256) ? 31 : (DEPTH <= 512) ? 63 : 127;

  fifoStb_t          stb;
  logic [AW-1:0]     wrAddr, rdAddr;
  logic [OFS_W-1:0]  aeOfs, afOfs;

  fifo_ctrl #(.DEPTH(DEPTH), .OFS_W(OFS_W), .AW(AW)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .loadN(loadN),
    .aeOfs(aeOfs), .afOfs(afOfs),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .emptyN(emptyN), .almostFullN(almostFullN),
    .almostEmptyN(almostEmptyN), .halfFullN(halfFullN)
  );

  fifo_dp #(.DW(DW), .DEPTH(DEPTH), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS), .AW(AW)) uDp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dIn(dIn), .dOut(dOut), .aeOfs(aeOfs), .afOfs(afOfs)
  );
endmodule

// File: tb/sim_dc_prog_fifo.sv
`timescale 1ns/1ps
module sim_dc_prog_fifo;
  localparam int DW    = 18;
  localparam int DEPTH = 256;
  localparam int OFS_W = 12;
  localparam int DEF   = 31;   // R10 default for DEPTH 256

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic rstN = 1'b0, wrEnN = 1'b1, rdEnN = 1'b1, loadN = 1'b1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic fullN, emptyN, almostFullN, almostEmptyN, halfFullN;

  always #4    wrClk = ~wrClk;   // 125 MHz
  always #5.65 rdClk = ~rdClk;   // unrelated read clock

  dc_prog_fifo #(.DW(DW), .DEPTH(DEPTH), .OFS_W(OFS_W)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .loadN(loadN),
    .dIn(dIn), .dOut(dOut), .fullN(fullN), .emptyN(emptyN),
    .almostFullN(almostFullN), .almostEmptyN(almostEmptyN),
    .halfFullN(halfFullN)
  );

  // reference model
  logic [DW-1:0] q[$];
  int  aeM = DEF, afM = DEF;
  bit  wSelM = 0, rSelM = 0;
  logic [DW-1:0] lastOut = '0;
  int  seqVal = 0;
  int  nRun = 0, nFail = 0;

  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
  endtask

  task automatic checkFlags(input string ctx);
    int n = q.size();
    chkEq("R5", {ctx, " fullN"},        fullN,        (n == DEPTH) ? 0 : 1);
    chkEq("R6", {ctx, " emptyN"},       emptyN,       (n == 0) ? 0 : 1);
    chkEq("R7", {ctx, " almostEmptyN"}, almostEmptyN, (n <= aeM) ? 0 : 1);
    chkEq("R8", {ctx, " almostFullN"},  almostFullN,  ((DEPTH - n) <= afM) ? 0 : 1);
    chkEq("R9", {ctx, " halfFullN"},    halfFullN,    (n > DEPTH / 2) ? 0 : 1);
  endtask

  task automatic pushWord(input logic [DW-1:0] d, output bit acc);
    @(negedge wrClk);
    dIn = d; wrEnN = 1'b0;
    acc = fullN;
    @(negedge wrClk);
    wrEnN = 1'b1;
    if (acc) q.push_back(d);
  endtask

  task automatic popWord(input string req, output bit acc);
    logic [DW-1:0] exp;
    @(negedge rdClk);
    rdEnN = 1'b0;
    acc = emptyN;
    exp = acc ? q[0] : lastOut;
    @(negedge rdClk);
    rdEnN = 1'b1;
    if (acc) void'(q.pop_front());
    chkEq(req, acc ? "read data order" : "held output on blocked read", dOut, exp);
    lastOut = exp;
  endtask

  task automatic fillTo(input int n);
    bit a;
    while (q.size() < n) begin
      pushWord(DW'(seqVal * 37 + 5), a);
      seqVal++;
    end
  endtask

  task automatic drainAll();
    bit a;
    while (q.size() > 0) popWord("R4", a);
  endtask

  task automatic loadWrite(input int v);
    @(negedge wrClk);
    loadN = 1'b0; wrEnN = 1'b0; dIn = DW'(v);
    @(negedge wrClk);
    wrEnN = 1'b1; loadN = 1'b1;
    if (wSelM) afM = v; else aeM = v;
    wSelM = !wSelM;
  endtask

  task automatic loadRead(input string req);
    int exp;
    @(negedge rdClk);
    loadN = 1'b0; rdEnN = 1'b0;
    @(negedge rdClk);
    rdEnN = 1'b1; loadN = 1'b1;
    exp = rSelM ? afM : aeM;
    rSelM = !rSelM;
    chkEq(req, "offset readback", dOut, exp);
    lastOut = DW'(exp);
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    bit a;
    int sent, got;
    repeat (4) @(negedge wrClk);
    // R1: state during reset
    chkEq("R1", "fullN in reset", fullN, 1);
    chkEq("R1", "emptyN in reset", emptyN, 0);
    chkEq("R1", "almostEmptyN in reset", almostEmptyN, 0);
    chkEq("R1", "almostFullN in reset", almostFullN, 1);
    chkEq("R1", "halfFullN in reset", halfFullN, 1);
    chkEq("R1", "dOut in reset", dOut, 0);
    rstN = 1'b1;
    settle();
    checkFlags("R1 after reset");

    // R10 + R12: default offsets read back, almost-empty first
    loadRead("R10");
    loadRead("R12");
    chkEq("R12", "emptyN after readback", emptyN, 0);

    // thresholds at default offsets
    fillTo(1);  settle(); checkFlags("level 1");
    fillTo(31); settle(); checkFlags("level 31");
    fillTo(32); settle(); checkFlags("level 32");
    fillTo(128); settle(); checkFlags("level 128");
    fillTo(129); settle(); checkFlags("level 129");
    fillTo(224); settle(); checkFlags("level 224");
    fillTo(225); settle(); checkFlags("level 225");
    fillTo(255); settle(); checkFlags("level 255");
    fillTo(256); settle(); checkFlags("level 256");

    // R2: write attempt while full is dropped
    pushWord(18'h2ABCD, a);
    chkEq("R2", "write accepted when full", a, 0);
    settle(); checkFlags("R2 after blocked write");

    // R12: readback while holding data pops nothing
    loadRead("R12");
    loadRead("R12");
    settle(); checkFlags("R12 after readback with data");

    drainAll();
    settle(); checkFlags("drained");

    // R3: read attempt while empty leaves dOut unchanged
    popWord("R3", a);
    chkEq("R3", "read accepted when empty", a, 0);

    // R11: program offsets (AE=10, AF=20); no word pushed
    loadWrite(10);
    loadWrite(20);
    settle(); checkFlags("R11 after offset load");
    loadRead("R11");
    loadRead("R11");

    fillTo(10);  settle(); checkFlags("prog level 10");
    fillTo(11);  settle(); checkFlags("prog level 11");
    fillTo(235); settle(); checkFlags("prog level 235");
    fillTo(236); settle(); checkFlags("prog level 236");
    drainAll();
    settle(); checkFlags("prog drained");

    // R11: third load wraps to almost-empty offset
    loadWrite(5);
    loadRead("R11");
    loadRead("R11");
    fillTo(5); settle(); checkFlags("wrap level 5");
    fillTo(6); settle(); checkFlags("wrap level 6");
    drainAll();
    settle();

    // R4: concurrent traffic with random gaps
    sent = 0; got = 0;
    fork
      begin
        while (sent < 600) begin
          pushWord(DW'(seqVal * 101 + 3), a);
          if (a) begin sent++; seqVal++; end
          if ($urandom_range(0, 7) == 0) repeat ($urandom_range(1, 40)) @(negedge wrClk);
        end
      end
      begin
        while (got < 600) begin
          if (q.size() > 0 || emptyN) begin
            popWord("R4", a);
            if (a) got++;
          end else @(negedge rdClk);
          if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 30)) @(negedge rdClk);
        end
      end
    join
    settle(); checkFlags("after concurrent phase");

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule